// File: doc/BRIEF.md
# Serial EEPROM Port with Host Override

This block drives a three-wire serial EEPROM through four pins: chip select, serial clock, data into the device and data out of the device. Two masters share these pins. After reset, an internal sequencer reads every word of the device and hands each word to the rest of the chip on a one-cycle valid strobe. At all other times, software can bit-bang the pins through a small host control register.

Whether a device is fitted is learned from a strap. The pad that carries the serial clock is pulled high or low on the board. The block latches that level on the final clock edge of reset and keeps it unchanged afterwards. The automatic read runs only when the latched bit says a device is present.

Each read command is a start-and-read opcode `110` followed by the word address, most significant bit first. The sixteen data bits then follow, also most significant bit first. The serial clock is the system clock divided down. Outgoing data changes while the serial clock is low, and incoming data is sampled just after the serial clock rises.

Top module: `eeprom_port`

## Requirements
- R1: While the sequencer is idle, a host write drives the pins from its data bits: bit 2 to chip select, bit 1 to serial clock, bit 0 to data-in. The pins follow one clock after the write. All three bits reset to 0.
- R2: The host read word is a live, unregistered view of the following bits:

  | Bit | Content |
  |-----|---------|
  | 0 | current level of the device data-out pin |
  | 1 | stored host serial-clock bit |
  | 2 | stored host chip-select bit |
  | 3 | busy |
  | 4 | done |
  | 5 | detected |

- R3: The detected bit takes the strap level sampled on the last rising clock edge while `rst_n` is low: 1 for high, 0 for low. It does not change after reset ends, whatever the strap does.
- R4: The automatic read starts on the first clock after reset only when detected is 1. Otherwise busy and done stay 0 and the host keeps the pins.
- R5: Each command, sent with chip select high, is the bits `1`,`1`,`0` then the 6-bit word address MSB first. Data-in changes only while the serial clock is low.
- R6: The 16 data bits are sampled MSB first, one per serial clock rise. The word appears on `word_data_o` with its address on `word_addr_o`, qualified by a `word_valid_o` pulse one clock wide.
- R7: The sequencer reads addresses 0 to 63 in ascending order, giving exactly 64 words.
- R8: Before every command, chip select is low, with the serial clock low, for at least one serial clock period (2*SK_HALF clocks).
- R9: After the last word, busy clears and done sets and stays set. The pins then return to the host register bits.
- R10: Host writes made while busy is 1 are discarded, and the host bits keep their previous value.
- R11: During a command, the serial clock is high for SK_HALF clocks and low for SK_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sk_strap_i | input | 1 | Board strap level seen on the serial clock pad during reset |
| eep_cs_o | output | 1 | Chip select to the EEPROM |
| eep_sk_o | output | 1 | Serial clock to the EEPROM |
| eep_di_o | output | 1 | Serial data into the EEPROM |
| eep_do_i | input | 1 | Serial data out of the EEPROM |
| host_wr_i | input | 1 | Host write strobe for the control bits |
| host_wdata_i | input | 3 | Host write data: chip select, serial clock, data-in |
| host_rdata_o | output | 6 | Host read word: detected, done, busy, chip select, serial clock, live data-out |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_addr_o | output | 6 | Address of the presented word |
| word_data_o | output | 16 | Presented word |

## Verification
The checks assume three things about the inputs:
- The strap is settled before reset is released.
- The device data-out line changes only around falling serial clock edges, so it is steady when the sequencer samples it.
- Reset is not reasserted in the middle of a command.

The bench keeps to these assumptions. It moves the strap only at clock negative edges before the final reset edge. It drives data-out from a behavioural EEPROM that updates on detected serial clock falls. During the host vector walk, the bench drives the data-out line directly, and no command framing is checked there.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_READ = 3'b110;

  // one idle slot, the opcode, the address and the data bits
  function automatic int frame_slots(input int aw, input int dw);
    return 1 + OPC_W + aw + dw;
  endfunction

  // level for data-in during a given slot; slot 0 is the idle gap
  function automatic logic cmd_bit(input logic [15:0] addr, input int unsigned aw,
                                   input int unsigned slot);
    logic [OPC_W-1:0] op_sh;
    logic [15:0]      ad_sh;
    logic             b;
    b     = 1'b0;
    op_sh = '0;
    ad_sh = '0;
    if (slot >= 1 && slot <= OPC_W) begin
      op_sh = OPC_READ >> (OPC_W - slot);
      b     = op_sh[0];
    end else if (slot > OPC_W && slot <= OPC_W + aw) begin
      ad_sh = addr >> (aw + OPC_W - slot);
      b     = ad_sh[0];
    end
    return b;
  endfunction

endpackage

// File: rtl/eep_detect.sv
module eep_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_i,
  output logic det_o
);

  // follows the strap on every edge in reset; the last such edge wins
  always_ff @(posedge clk) begin
    if (!rst_n) det_o <= strap_i;
  end

endmodule

// File: rtl/eep_host_reg.sv
module eep_host_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       lock_i,
  output logic       cs_o,
  output logic       sk_o,
  output logic       di_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_o <= 1'b0;
      sk_o <= 1'b0;
      di_o <= 1'b0;
    end else if (wr_i && !lock_i) begin
      cs_o <= wdata_i[2];
      sk_o <= wdata_i[1];
      di_o <= wdata_i[0];
    end
  end

endmodule

// File: rtl/eep_read_seq.sv
module eep_read_seq #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int SK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              det_i,
  input  logic              sd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              sample_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int SLOTS   = eep_pkg::frame_slots(ADDR_W, DATA_W);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int PH_W    = $clog2(2 * SK_HALF);
  localparam int CMD_END = eep_pkg::OPC_W + ADDR_W;

  logic              armed;
  logic [SLOT_W-1:0] slot;
  logic [PH_W-1:0]   phase;
  logic [ADDR_W-1:0] word;
  logic [DATA_W-1:0] shreg;

  logic last_phase, last_slot, last_word;

  assign last_phase = (phase == PH_W'(2 * SK_HALF - 1));
  assign last_slot  = (slot == SLOT_W'(SLOTS - 1));
  assign last_word  = &word;
  assign sample_o   = busy_o && (phase == PH_W'(SK_HALF)) && (slot > SLOT_W'(CMD_END));

  assign cs_o = busy_o && (slot != '0);
  assign sk_o = cs_o && (phase >= PH_W'(SK_HALF));
  assign di_o = cs_o && eep_pkg::cmd_bit(16'(word), ADDR_W, 32'(slot));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b1;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      slot    <= '0;
      phase   <= '0;
      word    <= '0;
      shreg   <= '0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      armed   <= 1'b0;
      if (armed && det_i) busy_o <= 1'b1;
      if (busy_o) begin
        if (sample_o) begin
          shreg <= {shreg[DATA_W-2:0], sd_i};
          if (last_slot) begin
            data_o  <= {shreg[DATA_W-2:0], sd_i};
            addr_o  <= word;
            valid_o <= 1'b1;
          end
        end
        if (last_phase) begin
          phase <= '0;
          if (last_slot) begin
            slot <= '0;
            word <= word + 1'b1;
            if (last_word) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
            end
          end else begin
            slot <= slot + 1'b1;
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_port.sv
module eeprom_port #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int SK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sk_strap_i,
  output logic              eep_cs_o,
  output logic              eep_sk_o,
  output logic              eep_di_o,
  input  logic              eep_do_i,
  input  logic              host_wr_i,
  input  logic [2:0]        host_wdata_i,
  output logic [5:0]        host_rdata_o,
  output logic              word_valid_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [DATA_W-1:0] word_data_o
);

  logic det;
  logic seq_busy, seq_done, seq_cs, seq_sk, seq_di, seq_sample;
  logic host_cs, host_sk, host_di;

  eep_detect u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (sk_strap_i),
    .det_o   (det)
  );

  eep_host_reg u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (host_wr_i),
    .wdata_i (host_wdata_i),
    .lock_i  (seq_busy),
    .cs_o    (host_cs),
    .sk_o    (host_sk),
    .di_o    (host_di)
  );

  eep_read_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SK_HALF (SK_HALF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_i    (det),
    .sd_i     (eep_do_i),
    .busy_o   (seq_busy),
    .done_o   (seq_done),
    .cs_o     (seq_cs),
    .sk_o     (seq_sk),
    .di_o     (seq_di),
    .sample_o (seq_sample),
    .valid_o  (word_valid_o),
    .addr_o   (word_addr_o),
    .data_o   (word_data_o)
  );

  // pin ownership: the sequencer while busy, the host otherwise
  always_comb begin
    if (seq_busy) begin
      eep_cs_o = seq_cs;
      eep_sk_o = seq_sk;
      eep_di_o = seq_di;
    end else begin
      eep_cs_o = host_cs;
      eep_sk_o = host_sk;
      eep_di_o = host_di;
    end
  end

  assign host_rdata_o = {det, seq_done, seq_busy, host_cs, host_sk, eep_do_i};

endmodule

// File: rtl/eeprom_port_chk.sv
module eeprom_port_chk (
  input logic clk,
  input logic rst_n,
  input logic det,
  input logic seq_busy,
  input logic seq_done,
  input logic seq_sample,
  input logic host_cs,
  input logic host_sk,
  input logic host_di,
  input logic host_wr_i,
  input logic eep_cs_o,
  input logic eep_sk_o,
  input logic eep_di_o,
  input logic word_valid_o
);

  AST_HOST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && host_wr_i) |=> ($stable(host_cs) && $stable(host_sk) && $stable(host_di))); // R10

  AST_DET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(det)); // R3

  AST_NO_START_UNDET: assert property (@(posedge clk) disable iff (!rst_n)
    !det |-> !seq_busy); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_busy); // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o); // R6

  AST_SAMPLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    seq_sample |-> (eep_cs_o && eep_sk_o)); // R6

  AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && eep_sk_o) |=> (!eep_sk_o || $stable(eep_di_o))); // R5

  AST_GAP_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !eep_cs_o) |-> !eep_sk_o); // R8

endmodule

bind eeprom_port eeprom_port_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .det          (det),
  .seq_busy     (seq_busy),
  .seq_done     (seq_done),
  .seq_sample   (seq_sample),
  .host_cs      (host_cs),
  .host_sk      (host_sk),
  .host_di      (host_di),
  .host_wr_i    (host_wr_i),
  .eep_cs_o     (eep_cs_o),
  .eep_sk_o     (eep_sk_o),
  .eep_di_o     (eep_di_o),
  .word_valid_o (word_valid_o)
);

// File: tb/eeprom_port_test.sv
`timescale 1ns/1ps
module eeprom_port_test;

  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int HALF = 2;
  localparam int NW   = 64;

  typedef struct packed {
    logic [2:0] wr;
    logic       sdo;
    logic [2:0] pins;
    logic [5:0] rd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'b100, 1'b0, 3'b100, 6'b000100},
    '{3'b110, 1'b0, 3'b110, 6'b000110},
    '{3'b111, 1'b1, 3'b111, 6'b000111},
    '{3'b101, 1'b0, 3'b101, 6'b000100},
    '{3'b011, 1'b1, 3'b011, 6'b000011},
    '{3'b001, 1'b0, 3'b001, 6'b000000},
    '{3'b010, 1'b1, 3'b010, 6'b000011},
    '{3'b000, 1'b1, 3'b000, 6'b000001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic host_wr = 1'b0;
  logic [2:0] host_wd = 3'b000;
  logic tb_do = 1'b0;
  logic model_do = 1'b0;
  logic use_model = 1'b0;
  logic do_line;
  logic cs, sk, di, vld;
  logic [5:0] rd;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign do_line = use_model ? model_do : tb_do;

  always #2 clk = ~clk;

  eeprom_port #(.ADDR_W(AW), .DATA_W(DW), .SK_HALF(HALF)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sk_strap_i   (strap),
    .eep_cs_o     (cs),
    .eep_sk_o     (sk),
    .eep_di_o     (di),
    .eep_do_i     (do_line),
    .host_wr_i    (host_wr),
    .host_wdata_i (host_wd),
    .host_rdata_o (rd),
    .word_valid_o (vld),
    .word_addr_o  (waddr),
    .word_data_o  (wdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rom(input int a);
    return 16'(a * 16'h0123) ^ 16'hA55A;
  endfunction

  // behavioural EEPROM: takes 9 command bits on sk rises, then shifts data out on sk falls
  logic       prev_sk = 1'b0;
  int         nbits = 0;
  logic [8:0] cmd = '0;
  int         dptr = -1;
  int         cur_addr = 0;
  int         exp_cmd = 0;
  logic [15:0] mword;

  always @(negedge clk) begin
    if (use_model) begin
      if (!cs) begin
        nbits = 0;
      end else if (sk && !prev_sk && nbits < 9) begin
        cmd = {cmd[7:0], di};
        nbits++;
        if (nbits == 9) begin
          check(cmd == {3'b110, 6'(exp_cmd)}, "R5 command bits", cmd, {3'b110, 6'(exp_cmd)});
          cur_addr = int'(cmd[5:0]);
          exp_cmd++;
          dptr = 15;
        end
      end else if (!sk && prev_sk && nbits == 9 && dptr >= 0) begin
        mword = rom(cur_addr);
        model_do = mword[dptr];
        dptr--;
      end
      prev_sk = sk;
    end
  end

  // word, gap and clock-width monitor
  int nwords = 0;
  int gap = 0;
  int hi = 0;
  int lo = 0;

  always @(negedge clk) begin
    if (use_model) begin
      if (vld) begin
        check(int'(waddr) == nwords, "R7 word order", waddr, nwords);
        check(wdata == rom(nwords), "R6 word data", wdata, rom(nwords));
        nwords++;
      end
      if (rd[3] && !cs) begin
        gap++;
      end else if (rd[3] && cs && gap > 0) begin
        check(gap >= 2 * HALF, "R8 select gap", gap, 2 * HALF);
        gap = 0;
      end
      if (rd[3] && cs) begin
        if (sk) begin
          hi++;
          if (lo > 0) begin
            check(lo == HALF, "R11 sk low width", lo, HALF);
            lo = 0;
          end
        end else begin
          lo++;
          if (hi > 0) begin
            check(hi == HALF, "R11 sk high width", hi, HALF);
            hi = 0;
          end
        end
      end else begin
        hi = 0;
        lo = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // undetected reset
    rst_n = 1'b0;
    strap = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs, sk, di} == 3'b000, "R1 reset pins", {cs, sk, di}, 0);
    check(rd == 6'b000000, "R2 reset read word", rd, 0);
    check(vld == 1'b0, "R6 reset valid", vld, 0);
    repeat (200) @(negedge clk);
    check(rd[4:3] == 2'b00, "R4 no read when undetected", rd[4:3], 0);
    check(cs == 1'b0, "R4 pins stay host", cs, 0);

    // host vector walk
    for (int i = 0; i < NV; i++) begin
      host_wd = VEC[i].wr;
      tb_do   = VEC[i].sdo;
      host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      check({cs, sk, di} == VEC[i].pins, "R1 host pins", {cs, sk, di}, VEC[i].pins);
      check(rd == VEC[i].rd, "R2 host read word", rd, VEC[i].rd);
    end
    tb_do = 1'b0;
    #1;
    check(rd[0] == 1'b0, "R2 live data-out", rd[0], 0);

    // strap high early, low on the final reset edge
    @(negedge clk);
    rst_n = 1'b0;
    strap = 1'b1;
    repeat (4) @(negedge clk);
    strap = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    strap = 1'b1;
    repeat (30) @(negedge clk);
    check(rd[5] == 1'b0, "R3 last edge low", rd[5], 0);
    check(rd[3] == 1'b0, "R4 no start", rd[3], 0);

    // strap low early, high on the final reset edge: full read
    use_model = 1'b1;
    rst_n = 1'b0;
    strap = 1'b0;
    repeat (3) @(negedge clk);
    strap = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    strap = 1'b0;
    @(negedge clk);
    check(rd[5] == 1'b1, "R3 last edge high", rd[5], 1);
    check(rd[3] == 1'b1, "R4 busy after reset", rd[3], 1);
    host_wd = 3'b111;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check(rd[2:1] == 2'b00, "R10 write ignored", rd[2:1], 0);

    for (int n = 0; n < 20000 && !rd[4]; n++) @(negedge clk);
    check(rd[4] == 1'b1, "R9 done set", rd[4], 1);
    check(rd[3] == 1'b0, "R9 busy clear", rd[3], 0);
    check(nwords == NW, "R7 word count", nwords, NW);
    check(exp_cmd == NW, "R5 command count", exp_cmd, NW);
    check(rd[2:1] == 2'b00, "R10 host bits kept", rd[2:1], 0);
    check({cs, sk, di} == 3'b000, "R9 pins back to host", {cs, sk, di}, 0);
    check(rd[5] == 1'b1, "R3 held after reset", rd[5], 1);

    host_wd = 3'b101;
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check({cs, sk, di} == 3'b101, "R9 host owns pins", {cs, sk, di}, 3'b101);
    repeat (10) @(negedge clk);
    check(rd[4] == 1'b1, "R9 done stays set", rd[4], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule